// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time clock peripheral that sits on a plain 32-bit register bus. The bus has a read strobe, a write strobe, a 12-bit byte address, write data and combinational read data. The block holds a free-running seconds counter. The counter advances once for every cycle in which the one-per-second enable input is high. Software can preset the counter through a load register.

A match register holds an alarm time. When the counter takes on the match value, a sticky raw status bit is set. This also happens after the counter wraps past zero, and it also happens when software writes a match value or a load value equal to the count. A one-bit mask gates the raw status onto the interrupt output. The raw status and the masked status can both be read back. A clear register drops the raw status on any write.

The control register always reads as enabled. A small read-only table of identification bytes fills the top of the address window. Every other offset reads as zero and has no effect.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the counter, match, load, mask and raw status all read 0. Every register then reads 0, except the control register at 0x0C, which reads 1.
- R2: On every clock edge with tick_i high and no load write, the counter (read at 0x00) increases by one, modulo 2^32. With tick_i low it holds.
- R3: A write to the load register (0x08) sets the counter to the written value on the next edge, and this wins over a tick in the same cycle. Reading 0x08 returns the value last written.
- R4: The match register at 0x04 reads back as written. The raw status (bit 0 of 0x14) becomes 1 in the same cycle in which the counter first shows the match value, whether the counter got there by a tick or by a load.
- R5: Matching wraps: a match value below the count fires after the counter rolls from 0xFFFFFFFF to 0.
- R6: Writing a match value equal to the current count sets the raw status on the next edge.
- R7: The mask register (0x10) keeps only bit 0 of the written data. irq_o and the masked status at 0x18 both equal raw status AND mask, and they follow a mask write on the next edge.
- R8: A write of any data to the clear register (0x1C) clears the raw status.
- R9: If a clear write and a match event fall in the same cycle, the match wins and the raw status stays 1.
- R10: The control register (0x0C) always reads 1, and writes to it have no effect.
- R11: Reads from 0xFE0 to 0xFFF return identification byte k, where k = (offset - 0xFE0) >> 2. The bytes for k = 0 to 7 are 0x52, 0x54, 0x43, 0x01, 0x5A, 0xA5, 0xC3, 0x3C.
- R12: A read of 0x1C or of any undecoded offset returns 0 and changes no state. rdata_o is 0 whenever rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-per-second count enable |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Alarm interrupt, raw AND mask |

## Verification
Two things can act on the raw status in the same cycle: a clear write and a match event. To provoke the collision, the bench writes the clear register while tick_i is high, so the counter steps onto the match value at the very edge that receives the clear. The raw status is then read back and is expected to be 1. A clear with no tick must instead read 0. The bench also lets a load write and a tick land in the same cycle, and it expects the loaded value to win.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_CNT  = 'h00;
  localparam int unsigned OFS_MR   = 'h04;
  localparam int unsigned OFS_LR   = 'h08;
  localparam int unsigned OFS_CR   = 'h0C;
  localparam int unsigned OFS_IM   = 'h10;
  localparam int unsigned OFS_RIS  = 'h14;
  localparam int unsigned OFS_MIS  = 'h18;
  localparam int unsigned OFS_CLR  = 'h1C;
  localparam int unsigned OFS_ID_LO = 'hFE0;
  localparam int unsigned OFS_ID_HI = 'hFFF;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h52;
      3'd1: id_byte = 8'h54;
      3'd2: id_byte = 8'h43;
      3'd3: id_byte = 8'h01;
      3'd4: id_byte = 8'h5A;
      3'd5: id_byte = 8'hA5;
      3'd6: id_byte = 8'hC3;
      default: id_byte = 8'h3C;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cnt_nxt_o,
  output logic              cnt_chg_o,
  output logic [DATA_W-1:0] lr_o
);
  logic [DATA_W-1:0] cnt_q, lr_q;

  // load beats tick
  always_comb begin
    if (load_i)      cnt_nxt_o = load_val_i;
    else if (tick_i) cnt_nxt_o = cnt_q + DATA_W'(1);
    else             cnt_nxt_o = cnt_q;
  end
  assign cnt_chg_o = load_i | tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (load_i) lr_q <= load_val_i;
    end
  end

  assign cnt_o = cnt_q;
  assign lr_o  = lr_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cnt_nxt_i,
  input  logic              cnt_chg_i,
  input  logic              mr_wr_i,
  input  logic              im_wr_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mr_o,
  output logic              im_o,
  output logic              is_o
);
  logic [DATA_W-1:0] mr_q, mr_nxt;
  logic im_q, is_q, evt;

  assign mr_nxt = mr_wr_i ? wdata_i : mr_q;
  // event only when count or match moves onto equality; wraps naturally
  assign evt = (cnt_chg_i | mr_wr_i) & (cnt_nxt_i == mr_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr_q <= '0;
      im_q <= 1'b0;
      is_q <= 1'b0;
    end else begin
      mr_q <= mr_nxt;
      if (im_wr_i) im_q <= wdata_i[0];
      if (evt)        is_q <= 1'b1;
      else if (clr_i) is_q <= 1'b0;
    end
  end

  assign mr_o = mr_q;
  assign im_o = im_q;
  assign is_o = is_q;
endmodule

// File: rtl/rtc_rdmux.sv
module rtc_rdmux
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] mr_i,
  input  logic [DATA_W-1:0] lr_i,
  input  logic              im_i,
  input  logic              is_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_LSB = 2;
  logic [DATA_W-1:0] mux;
  logic [ADDR_W-1:0] id_ofs;

  assign id_ofs = addr_i - ADDR_W'(OFS_ID_LO);

  always_comb begin
    mux = '0;
    if (addr_i >= ADDR_W'(OFS_ID_LO) && addr_i <= ADDR_W'(OFS_ID_HI)) begin
      mux = DATA_W'(id_byte(id_ofs[IDX_LSB+:3]));
    end else begin
      case (addr_i)
        ADDR_W'(OFS_CNT): mux = cnt_i;
        ADDR_W'(OFS_MR):  mux = mr_i;
        ADDR_W'(OFS_LR):  mux = lr_i;
        ADDR_W'(OFS_CR):  mux = DATA_W'(1);
        ADDR_W'(OFS_IM):  mux = DATA_W'(im_i);
        ADDR_W'(OFS_RIS): mux = DATA_W'(is_i);
        ADDR_W'(OFS_MIS): mux = DATA_W'(is_i & im_i);
        default:          mux = '0;
      endcase
    end
  end

  assign rdata_o = rd_i ? mux : '0;
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic lr_wr, mr_wr, im_wr, clr_wr;
  logic [DATA_W-1:0] cnt_q, cnt_nxt, lr_q, mr_q;
  logic cnt_chg, im_q, is_q;

  assign lr_wr  = wr_i && (addr_i == ADDR_W'(OFS_LR));
  assign mr_wr  = wr_i && (addr_i == ADDR_W'(OFS_MR));
  assign im_wr  = wr_i && (addr_i == ADDR_W'(OFS_IM));
  assign clr_wr = wr_i && (addr_i == ADDR_W'(OFS_CLR));

  rtc_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (lr_wr),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_q),
    .cnt_nxt_o  (cnt_nxt),
    .cnt_chg_o  (cnt_chg),
    .lr_o       (lr_q)
  );

  rtc_alarm #(.DATA_W(DATA_W)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_i (cnt_nxt),
    .cnt_chg_i (cnt_chg),
    .mr_wr_i   (mr_wr),
    .im_wr_i   (im_wr),
    .clr_i     (clr_wr),
    .wdata_i   (wdata_i),
    .mr_o      (mr_q),
    .im_o      (im_q),
    .is_o      (is_q)
  );

  rtc_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt_q),
    .mr_i    (mr_q),
    .lr_i    (lr_q),
    .im_i    (im_q),
    .is_i    (is_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = is_q & im_q;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mr_q,
  input logic              is_q
);
  logic lr_w, clr_w;
  assign lr_w  = wr_i && (addr_i == ADDR_W'(OFS_LR));
  assign clr_w = wr_i && (addr_i == ADDR_W'(OFS_CLR));

  a_r2_tick_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !lr_w) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_w |=> (cnt_q == $past(wdata_i)));

  a_r4_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(is_q) |-> (cnt_q == mr_q));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !tick_i) |=> !is_q);

  a_r7_mis_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(OFS_MIS)) |-> (rdata_o[0] == irq_o));

  a_r10_cr_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(OFS_CR)) |-> (rdata_o == DATA_W'(1)));

  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

bind rtc_alarm_top rtc_alarm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .mr_q    (mr_q),
  .is_q    (is_q)
);

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] v;

  rtc_alarm_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] exp_id(input int k);
    logic [7:0] t [8] = '{8'h52, 8'h54, 8'h43, 8'h01, 8'h5A, 8'hA5, 8'hC3, 8'h3C};
    return t[k];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a; rd_i = 1'b1;
    #1;
    d = rdata_o;
    rd_i = 1'b0;
    #1;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    for (int a = 0; a < 'h20; a += 4) begin
      rd(12'(a), v);
      check("R1", v, (a == 'h0C) ? 32'd1 : 32'd0);
    end
    check("R1 irq", {31'd0, irq_o}, 32'd0);

    // R12 idle read bus
    check("R12 idle", rdata_o, 32'd0);

    // R2 counting, with gaps
    ticks(5);
    rd('h00, v); check("R2", v, 32'd5);
    repeat (4) @(negedge clk_i);
    rd('h00, v); check("R2 hold", v, 32'd5);
    ticks(17);
    rd('h00, v); check("R2", v, 32'd22);

    // R3 load, readback, load beats tick
    wr('h08, 32'h1234_5678);
    rd('h00, v); check("R3 cnt", v, 32'h1234_5678);
    rd('h08, v); check("R3 lr", v, 32'h1234_5678);
    @(negedge clk_i);
    tick_i = 1'b1; wr_i = 1'b1; addr_i = 'h08; wdata_i = 32'd100;
    @(negedge clk_i);
    tick_i = 1'b0; wr_i = 1'b0;
    rd('h00, v); check("R3 load over tick", v, 32'd100);

    // R4 match by tick, sweep distance
    for (int d = 1; d <= 6; d++) begin
      wr('h1C, 32'd0);
      wr('h08, 32'd1000);
      wr('h04, 32'd1000 + 32'(d));
      rd('h04, v); check("R4 mr", v, 32'd1000 + 32'(d));
      if (d > 1) begin
        ticks(d - 1);
        rd('h14, v); check("R4 early", v, 32'd0);
        ticks(1);
      end else begin
        ticks(1);
      end
      rd('h14, v); check("R4 fire", v, 32'd1);
    end
    // R4 match by load
    wr('h1C, 32'd0);
    wr('h04, 32'd777);
    wr('h08, 32'd777);
    rd('h14, v); check("R4 load hit", v, 32'd1);

    // R5 wraparound
    wr('h08, 32'hFFFF_FFFE);
    wr('h04, 32'd1);
    wr('h1C, 32'd0);
    ticks(2);
    rd('h00, v); check("R5 wrap cnt", v, 32'd0);
    rd('h14, v); check("R5 not yet", v, 32'd0);
    ticks(1);
    rd('h14, v); check("R5 fire", v, 32'd1);

    // R6 match written equal to count
    wr('h1C, 32'd0);
    wr('h08, 32'd4242);
    rd('h14, v); check("R6 pre", v, 32'd0);
    wr('h04, 32'd4242);
    rd('h14, v); check("R6 immediate", v, 32'd1);

    // R7 mask x raw sweep
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        wr('h1C, 32'd0);
        if (s == 1) wr('h04, 32'd4242);
        wr('h10, m ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
        rd('h10, v); check("R7 mask bit0", v, 32'(m));
        rd('h18, v); check("R7 mis", v, 32'(s & m));
        check("R7 irq", {31'd0, irq_o}, 32'(s & m));
      end
    end

    // R8 clear with various data
    foreach (v[i]) begin
      if (i % 8 != 0) continue;
      wr('h04, 32'd4242);
      wr('h1C, 32'd1 << i);
      rd('h14, v); check("R8 clear", v, 32'd0);
    end
    wr('h04, 32'd4242);
    wr('h1C, 32'd0);
    rd('h14, v); check("R8 clear zero data", v, 32'd0);
    check("R8 irq low", {31'd0, irq_o}, 32'd0);

    // R9 clear and match in the same cycle
    wr('h08, 32'd10);
    wr('h04, 32'd11);
    wr('h1C, 32'd0);
    rd('h14, v); check("R9 pre", v, 32'd0);
    @(negedge clk_i);
    tick_i = 1'b1; wr_i = 1'b1; addr_i = 'h1C; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    tick_i = 1'b0; wr_i = 1'b0;
    rd('h00, v); check("R9 cnt", v, 32'd11);
    rd('h14, v); check("R9 match wins", v, 32'd1);

    // R10 control reads 1, writes ignored
    wr('h0C, 32'd0);
    rd('h0C, v); check("R10", v, 32'd1);

    // R11 identification sweep over every byte offset
    for (int a = 'hFE0; a <= 'hFFF; a++) begin
      rd(12'(a), v);
      check("R11", v, {24'd0, exp_id((a - 'hFE0) >> 2)});
    end

    // R12 undecoded and clear-register reads: zero, no side effect
    rd('h00, v);
    for (int a = 'h1C; a < 'hFE0; a += 4) begin
      logic [31:0] r;
      rd(12'(a), r);
      if (r !== 32'd0) check("R12 zero", r, 32'd0);
    end
    n_chk++;
    begin
      logic [31:0] c2, s2;
      rd('h00, c2); check("R12 cnt kept", c2, v);
      rd('h14, s2); check("R12 ris kept", s2, 32'd1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule